// File: doc/BRIEF.md
# Basic-Mode Parallel Port Bank

This block models four programmable parallel port devices, each locked to plain input/output operation. Every device has three byte-wide ports (A, B, C); port C is split into a lower and an upper nibble, and each of the four groups (A, B, C-low, C-high) has its own direction. Software reaches all of it through a byte-wide register bus. There are data registers per port, a write-only control word per device, and two read-only configuration registers. The configuration registers report the direction each group is actually using.

A strap input per group forces that group to drive, whatever the control word says. This lets a board fix outputs in hardware. The pins are presented as separate input, output and output-enable vectors for an external pad ring. A reset-mode select decides whether a bus reset clears the bank or leaves its state held until a power-on reset.

Top module: `pio_mode0_emu`

## Requirements
- R1: A control word for device n is written at offset 4n+3. It is accepted when bits 7..5 are 100 and bit 2 is 0. Bit 4 sets the direction of port A, bit 3 of C-high, bit 1 of B and bit 0 of C-low; a 1 selects input and a 0 selects output.
- R2: Device n drives pins 24n..24n+23 on `pin_out`/`pin_oe`. Port A is on bits +0..+7, B on +8..+15, C-low on +16..+19 and C-high on +20..+23. `pin_oe` is 1 on every pin of a group whose effective direction is output.
- R3: `strap` bit 4n+0 belongs to A, 4n+1 to B, 4n+2 to C-low and 4n+3 to C-high of device n. A set strap makes that group an output regardless of the control word. A clear strap leaves the control word in charge.
- R4: After power-on reset, every group without a strap is an input and every output latch is zero.
- R5: The data ports of device n are read and written at offsets 4n, 4n+1 and 4n+2. A read at 0x03, 0x07 or 0x0B, or at any offset outside the map, returns 0x00. Offset 0x0F writes the control word of device 3 but reads configuration (R6).
- R6: A read of 0x14 returns devices 0 and 1, and a read of 0x0F returns devices 2 and 3. Bits 7..0 are: first device C-low, B, C-high, A, then second device C-low, B, C-high, A. A 1 means the group is an output.
- R7: A port read returns the output latch on bits whose group is an output and the pin input on bits whose group is an input. `rd_data` shows the value for `addr` one clock after `addr` is presented.
- R8: When `hold_on_bus_rst` is 0, `bus_rst` clears the latches and returns all directions to input. When it is 1, `bus_rst` changes nothing. `por_rst` always clears.
- R9: A control word write that fails the bit pattern of R1 changes no direction.
- R10: A write to a port whose group is an input updates its output latch and `pin_out` but leaves `pin_oe` low. The value is read back once the group turns to output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on reset, active high |
| bus_rst | input | 1 | Synchronous bus reset, active high |
| hold_on_bus_rst | input | 1 | 1: bus reset leaves state held |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| strap | input | 16 | Per-group force-to-output straps |
| pin_in | input | 96 | Pin input levels |
| pin_out | output | 96 | Output latch values |
| pin_oe | output | 96 | Output enables |

## Verification
All sixteen direction combinations are written to each device and checked against `pin_oe`, the configuration registers and every port read. This separates the four group bits from one another and from the other devices. For one device, every strap pattern is crossed with every direction pattern, which tells strap priority apart from software control. The output-read and input-read paths are told apart by driving `pin_in` with values that differ from the latches. Malformed control words, both reset modes and writes made while a group is an input show whether state is kept or cleared.

// File: rtl/pio_mode0_pkg.sv
package pio_mode0_pkg;
  localparam int unsigned NUM_CHIPS = 4;
  localparam int unsigned PORT_W    = 8;
  localparam int unsigned NIB_W     = PORT_W / 2;
  localparam int unsigned NUM_PORTS = 3;
  localparam int unsigned NUM_GRPS  = 4;
  localparam int unsigned CHIP_PINS = NUM_PORTS * PORT_W;
  localparam int unsigned ALL_PINS  = NUM_CHIPS * CHIP_PINS;
  localparam int unsigned ADDR_W    = 5;

  localparam logic [ADDR_W-1:0] CFG01_OFS = 5'h14;
  localparam logic [ADDR_W-1:0] CFG23_OFS = 5'h0F;
  localparam logic [1:0]        SEL_CTL   = 2'd3;

  // group index inside one device
  localparam int unsigned G_A   = 0;
  localparam int unsigned G_B   = 1;
  localparam int unsigned G_CLO = 2;
  localparam int unsigned G_CHI = 3;

  function automatic logic ctl_ok(input logic [PORT_W-1:0] d);
    return d[7] & ~d[6] & ~d[5] & ~d[2];
  endfunction

  // returns per-group "is input" flags, indexed by group number
  function automatic logic [NUM_GRPS-1:0] ctl_in_flags(input logic [PORT_W-1:0] d);
    return {d[3], d[0], d[1], d[4]};
  endfunction
endpackage

// File: rtl/pio_mode0_chip.sv
module pio_mode0_chip
  import pio_mode0_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           sel,
  input  logic [PORT_W-1:0]    wr_data,
  input  logic [NUM_GRPS-1:0]  strap,
  input  logic [CHIP_PINS-1:0] pin_in,
  output logic [CHIP_PINS-1:0] pin_out,
  output logic [CHIP_PINS-1:0] pin_oe,
  output logic [CHIP_PINS-1:0] rd_port,
  output logic [NUM_GRPS-1:0]  cfg
);
  logic [NUM_GRPS-1:0] sw_in;
  logic [NUM_GRPS-1:0] grp_out;
  logic [PORT_W-1:0]   lat [NUM_PORTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_in <= '1;
    end else if (wr_en && sel == SEL_CTL && ctl_ok(wr_data)) begin
      sw_in <= ctl_in_flags(wr_data);
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst) begin
        lat[p] <= '0;
      end else if (wr_en && sel == 2'(p)) begin
        lat[p] <= wr_data;
      end
    end
    assign pin_out[p*PORT_W +: PORT_W] = lat[p];
  end

  assign grp_out = strap | ~sw_in;

  assign pin_oe[0*PORT_W +: PORT_W]       = {PORT_W{grp_out[G_A]}};
  assign pin_oe[1*PORT_W +: PORT_W]       = {PORT_W{grp_out[G_B]}};
  assign pin_oe[2*PORT_W +: NIB_W]        = {NIB_W{grp_out[G_CLO]}};
  assign pin_oe[2*PORT_W+NIB_W +: NIB_W]  = {NIB_W{grp_out[G_CHI]}};

  assign rd_port = (pin_out & pin_oe) | (pin_in & ~pin_oe);

  assign cfg = {grp_out[G_CLO], grp_out[G_B], grp_out[G_CHI], grp_out[G_A]};
endmodule

// File: rtl/pio_mode0_rdmux.sv
module pio_mode0_rdmux
  import pio_mode0_pkg::*;
(
  input  logic [ADDR_W-1:0]          addr,
  input  logic [ALL_PINS-1:0]        rd_port_all,
  input  logic [NUM_CHIPS*NUM_GRPS-1:0] cfg_all,
  output logic [PORT_W-1:0]          rd_next
);
  logic [1:0] chip_idx;
  logic [1:0] port_idx;

  assign chip_idx = addr[3:2];
  assign port_idx = addr[1:0];

  always_comb begin
    rd_next = '0;
    if (addr == CFG01_OFS) begin
      rd_next = {cfg_all[0*NUM_GRPS +: NUM_GRPS], cfg_all[1*NUM_GRPS +: NUM_GRPS]};
    end else if (addr == CFG23_OFS) begin
      rd_next = {cfg_all[2*NUM_GRPS +: NUM_GRPS], cfg_all[3*NUM_GRPS +: NUM_GRPS]};
    end else if (!addr[4] && port_idx != SEL_CTL) begin
      rd_next = rd_port_all[chip_idx*CHIP_PINS + port_idx*PORT_W +: PORT_W];
    end
  end
endmodule

// File: rtl/pio_mode0_emu.sv
module pio_mode0_emu
  import pio_mode0_pkg::*;
(
  input  logic                          clk,
  input  logic                          por_rst,
  input  logic                          bus_rst,
  input  logic                          hold_on_bus_rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [PORT_W-1:0]             wr_data,
  output logic [PORT_W-1:0]             rd_data,
  input  logic [NUM_CHIPS*NUM_GRPS-1:0] strap,
  input  logic [ALL_PINS-1:0]           pin_in,
  output logic [ALL_PINS-1:0]           pin_out,
  output logic [ALL_PINS-1:0]           pin_oe
);
  logic                          rst_eff;
  logic [ALL_PINS-1:0]           rd_port_all;
  logic [NUM_CHIPS*NUM_GRPS-1:0] cfg_all;
  logic [PORT_W-1:0]             rd_next;

  assign rst_eff = por_rst | (bus_rst & ~hold_on_bus_rst);

  for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
    logic chip_wr;
    assign chip_wr = wr_en && !addr[4] && addr[3:2] == 2'(c);

    pio_mode0_chip u_chip (
      .clk     (clk),
      .rst     (rst_eff),
      .wr_en   (chip_wr),
      .sel     (addr[1:0]),
      .wr_data (wr_data),
      .strap   (strap[c*NUM_GRPS +: NUM_GRPS]),
      .pin_in  (pin_in[c*CHIP_PINS +: CHIP_PINS]),
      .pin_out (pin_out[c*CHIP_PINS +: CHIP_PINS]),
      .pin_oe  (pin_oe[c*CHIP_PINS +: CHIP_PINS]),
      .rd_port (rd_port_all[c*CHIP_PINS +: CHIP_PINS]),
      .cfg     (cfg_all[c*NUM_GRPS +: NUM_GRPS])
    );
  end

  pio_mode0_rdmux u_rdmux (
    .addr        (addr),
    .rd_port_all (rd_port_all),
    .cfg_all     (cfg_all),
    .rd_next     (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst_eff) rd_data <= '0;
    else         rd_data <= rd_next;
  end
endmodule

// File: rtl/pio_mode0_chk.sv
module pio_mode0_chk
  import pio_mode0_pkg::*;
(
  input logic                          clk,
  input logic                          por_rst,
  input logic                          bus_rst,
  input logic                          hold_on_bus_rst,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             addr,
  input logic [PORT_W-1:0]             wr_data,
  input logic [NUM_CHIPS*NUM_GRPS-1:0] strap,
  input logic [ALL_PINS-1:0]           pin_out,
  input logic [ALL_PINS-1:0]           pin_oe
);
  // R3: a strap on device 0 port A forces its pins to drive
  a_r3_strap_forces_oe: assert property (@(posedge clk) disable iff (por_rst)
    strap[G_A] |-> pin_oe[PORT_W-1:0] == '1);

  // R3: a strap on device 3 C-high forces its pins to drive
  a_r3_strap_chi_dev3: assert property (@(posedge clk) disable iff (por_rst)
    strap[3*NUM_GRPS+G_CHI] |-> pin_oe[3*CHIP_PINS+2*PORT_W+NIB_W +: NIB_W] == '1);

  // R4: power-on reset with no straps leaves every pin undriven and zero
  a_r4_por_all_input: assert property (@(posedge clk)
    (por_rst && strap == '0) ##1 (strap == '0) |-> (pin_oe == '0 && pin_out == '0));

  // R8: in hold mode a bus reset keeps the latches
  a_r8_hold_keeps_latch: assert property (@(posedge clk) disable iff (por_rst)
    (hold_on_bus_rst && bus_rst && !wr_en) |=> $stable(pin_out));

  // R9: a malformed control word to device 0 changes no direction
  a_r9_bad_ctl_ignored: assert property (@(posedge clk) disable iff (por_rst || bus_rst)
    (wr_en && addr == 5'h03 && !ctl_ok(wr_data)) |=> ($stable(pin_oe[CHIP_PINS-1:0]) || !$stable(strap[NUM_GRPS-1:0])));

  // R1: a valid control word sets port A direction of device 0 (1 = input)
  a_r1_ctl_dir_port_a: assert property (@(posedge clk) disable iff (por_rst || bus_rst)
    (wr_en && addr == 5'h03 && wr_data[7:5] == 3'b100 && !wr_data[2])
      |=> pin_oe[PORT_W-1:0] == {PORT_W{~$past(wr_data[4]) | strap[G_A]}});
endmodule

bind pio_mode0_emu pio_mode0_chk u_chk (
  .clk             (clk),
  .por_rst         (por_rst),
  .bus_rst         (bus_rst),
  .hold_on_bus_rst (hold_on_bus_rst),
  .wr_en           (wr_en),
  .addr            (addr),
  .wr_data         (wr_data),
  .strap           (strap),
  .pin_out         (pin_out),
  .pin_oe          (pin_oe)
);

// File: tb/pio_mode0_emu_tb.sv
module pio_mode0_emu_tb;
  logic        clk = 1'b0;
  logic        por_rst, bus_rst, hold_on_bus_rst, wr_en;
  logic [4:0]  addr;
  logic [7:0]  wr_data, rd_data;
  logic [15:0] strap;
  logic [95:0] pin_in, pin_out, pin_oe;

  always #5 clk = ~clk;

  pio_mode0_emu u_dut (
    .clk(clk), .por_rst(por_rst), .bus_rst(bus_rst), .hold_on_bus_rst(hold_on_bus_rst),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .strap(strap), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  // bench model: per-group input flag (A,B,Clo,Chi) and port latches
  logic [3:0] m_in  [4];
  logic [7:0] m_lat [4][3];

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      m_in[c] = 4'hF;
      for (int p = 0; p < 3; p++) m_lat[c][p] = 8'h00;
    end
  endtask

  function automatic logic go(input int c, input int g);
    return strap[4*c+g] | ~m_in[c][g];
  endfunction

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (!a[4]) begin
      if (a[1:0] == 2'd3) begin
        if (d[7:5] == 3'b100 && !d[2]) m_in[a[3:2]] = {d[3], d[0], d[1], d[4]};
      end else begin
        m_lat[a[3:2]][a[1:0]] = d;
      end
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic logic [7:0] ctl_word(input logic [3:0] in_flags);
    // in_flags: [0]=A [1]=B [2]=Clo [3]=Chi, 1 = input
    return {3'b100, in_flags[0], in_flags[3], 1'b0, in_flags[1], in_flags[2]};
  endfunction

  task automatic check_all(input string tag);
    logic [95:0] e_oe, e_out;
    logic [7:0]  v, e, msk;
    for (int c = 0; c < 4; c++) begin
      e_oe[24*c +: 8]    = {8{go(c,0)}};
      e_oe[24*c+8 +: 8]  = {8{go(c,1)}};
      e_oe[24*c+16 +: 4] = {4{go(c,2)}};
      e_oe[24*c+20 +: 4] = {4{go(c,3)}};
      for (int p = 0; p < 3; p++) e_out[24*c+8*p +: 8] = m_lat[c][p];
    end
    chk(pin_oe == e_oe, {tag, "/R2 pin_oe"}, pin_oe, e_oe);
    chk(pin_out == e_out, {tag, "/R10 pin_out"}, pin_out, e_out);
    rd(5'h14, v);
    e = {go(0,2), go(0,1), go(0,3), go(0,0), go(1,2), go(1,1), go(1,3), go(1,0)};
    chk(v == e, {tag, "/R6 cfg01"}, 96'(v), 96'(e));
    rd(5'h0F, v);
    e = {go(2,2), go(2,1), go(2,3), go(2,0), go(3,2), go(3,1), go(3,3), go(3,0)};
    chk(v == e, {tag, "/R6 cfg23"}, 96'(v), 96'(e));
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 3; p++) begin
        rd(5'(4*c+p), v);
        if (p == 2) msk = {{4{go(c,3)}}, {4{go(c,2)}}};
        else        msk = {8{go(c,p)}};
        e = (m_lat[c][p] & msk) | (pin_in[24*c+8*p +: 8] & ~msk);
        chk(v == e, {tag, "/R7 port read"}, 96'(v), 96'(e));
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    por_rst = 1; bus_rst = 0; hold_on_bus_rst = 0; wr_en = 0;
    addr = '0; wr_data = '0; strap = '0;
    pin_in = {3{32'hC35A960F}};
    model_reset();
    repeat (3) @(negedge clk);
    por_rst = 0;
    check_all("R4 reset");

    // R1: every direction pattern on every device
    for (int c = 0; c < 4; c++)
      for (int d = 0; d < 16; d++) begin
        wr(5'(4*c+3), ctl_word(4'(d)));
        check_all("R1 sweep");
      end

    // R3: all straps crossed with all directions on device 2
    for (int s = 0; s < 16; s++) begin
      strap[11:8] = 4'(s);
      for (int d = 0; d < 16; d++) begin
        wr(5'h0B, ctl_word(4'(d)));
        check_all("R3 strap");
      end
    end
    strap = '0;

    // R7: output read-back with pins differing from latches
    for (int c = 0; c < 4; c++) wr(5'(4*c+3), 8'h80);
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 3; p++) wr(5'(4*c+p), 8'(37*(4*c+p)+11));
    pin_in = ~pin_out;
    check_all("R7 readback");

    // R10: writes while input land in the latch only
    for (int c = 0; c < 4; c++) wr(5'(4*c+3), 8'h9B);
    for (int c = 0; c < 4; c++)
      for (int p = 0; p < 3; p++) wr(5'(4*c+p), 8'(16*c+p+8'h40));
    check_all("R10 input write");
    for (int c = 0; c < 4; c++) wr(5'(4*c+3), 8'h80);
    check_all("R10 turned output");

    // R9: malformed control words
    wr(5'h03, ctl_word(4'b0101));
    foreach (v[i]) ;
    wr(5'h03, 8'h1B); check_all("R9 d7 clear");
    wr(5'h03, 8'hC0); check_all("R9 d6 set");
    wr(5'h03, 8'hA0); check_all("R9 d5 set");
    wr(5'h03, 8'h9F); check_all("R9 d2 set");

    // R5: holes in the read map
    rd(5'h03, v); chk(v == 8'h00, "R5 ctl read 03", 96'(v), 96'h0);
    rd(5'h07, v); chk(v == 8'h00, "R5 ctl read 07", 96'(v), 96'h0);
    rd(5'h0B, v); chk(v == 8'h00, "R5 ctl read 0B", 96'(v), 96'h0);
    rd(5'h10, v); chk(v == 8'h00, "R5 unmapped 10", 96'(v), 96'h0);
    rd(5'h1F, v); chk(v == 8'h00, "R5 unmapped 1F", 96'(v), 96'h0);
    wr(5'h0F, 8'h89); check_all("R5 write 0F is dev3 ctl");

    // R8: hold mode keeps state across bus reset
    hold_on_bus_rst = 1;
    @(negedge clk); bus_rst = 1;
    repeat (2) @(negedge clk); bus_rst = 0;
    check_all("R8 hold");
    // R8: clear mode
    hold_on_bus_rst = 0;
    @(negedge clk); bus_rst = 1;
    repeat (2) @(negedge clk); bus_rst = 0;
    model_reset();
    check_all("R8 clear");
    // R8: power-on reset clears even in hold mode
    wr(5'h00, 8'h3C); wr(5'h03, 8'h80);
    hold_on_bus_rst = 1;
    @(negedge clk); por_rst = 1;
    repeat (2) @(negedge clk); por_rst = 0;
    model_reset();
    check_all("R8 por in hold");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule